// File: doc/BRIEF.md
# Register-Driven Reconfiguration Write Bridge

This block turns two host-visible 32-bit registers into write transactions on an internal reconfiguration bus. One register carries the value to be written. The other is a control word with four parts: a target address field, one write-request bit per target, a reset bit for the reconfiguration logic and a reset bit for the clock generator. Software writes the value, then the address, then sets and clears a write-request bit. The bridge synchronizes the control bits and detects the rising edge of the write-request bit. On that edge it launches exactly one bus write, which carries the value and the address. The write is held until the target stops asserting wait-request.

The two reset bits are synchronized and driven out as level, active-high resets. Software can pulse the clock-generator reset alone, for example after changing an output divider so that phase alignment is kept. It can also pulse both resets together. While either reset is active, the bridge drops any pending write and keeps the bus idle. A second write-request bit sends the same value and address to a second target lane, which has its own strobe and wait-request.

Top module: `cfg_write_bridge`

## Requirements
- R1: During and right after the synchronous active-low reset `rst_n`, every lane strobe, address, data and both reset outputs are 0.
- R2: Control bit 0 requests a write on lane 0 and bit 1 on lane 1, and the address field occupies control bits 13:8. After a 0-to-1 change of a request bit is first sampled at clock edge E0, the lane strobe rises at edge E2. The strobe carries the address field and the parameter value present at E2.
- R3: Keeping a request bit high produces only one write. A further write needs the bit to be cleared and set again.
- R4: While a lane's strobe is high and its wait-request is high, the strobe, address and data stay unchanged, even if the host registers change. The strobe falls at the first edge that samples wait-request low.
- R5: A rising edge of control bit 1 writes only on lane 1. Lane 0's outputs and write count are unaffected.
- R6: Control bit 2 (reconfiguration reset) and bit 3 (clock-generator reset) each appear on their own output one edge after they are first sampled. They act independently or together.
- R7: While either reset output is high, any pending write is cancelled on the next edge. A request-bit edge that occurs during that time produces no write, including after the reset is released.
- R8: A request-bit edge that arrives while the same lane still has a write pending is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_param_i | input | DATA_W | Parameter register value |
| host_ctrl_i | input | CTRL_W | Control register value |
| cfg_wr_o | output | NUM_TGT | Per-lane write strobe |
| cfg_wait_i | input | NUM_TGT | Per-lane wait-request from target |
| cfg_addr_o | output | NUM_TGT*ADDR_W | Per-lane address, lane i at bits i*ADDR_W |
| cfg_wdata_o | output | NUM_TGT*DATA_W | Per-lane write data, lane i at bits i*DATA_W |
| cfg_logic_rst_o | output | 1 | Reset to the reconfiguration logic |
| clkgen_rst_o | output | 1 | Reset to the clock generator |

## Verification
The first pattern is a single set-and-clear of a request bit with wait-request low. It checks the two-edge launch latency and the values the write carries. The second pattern holds the request bit high for many cycles and then clears and sets it again. This tells level triggering apart from edge triggering. A third pattern holds wait-request high while the host registers change and the request bit toggles. It shows whether the latched values stay put and whether a second edge is dropped. The last patterns raise the resets in the middle of a pending write and toggle a request bit under reset. They show whether the write is cancelled and whether an edge seen under reset is lost for good.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
   typedef enum logic {
      LANE_IDLE = 1'b0,
      LANE_BUSY = 1'b1
   } lane_state_e;

   localparam int unsigned CWB_MAX_TGT = 4;
endpackage

// File: rtl/cwb_sync.sv
module cwb_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("cwb_sync: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cwb_edge.sv
module cwb_edge #(
   parameter int unsigned WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/cwb_lane.sv
module cwb_lane
   import cwb_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              fire_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              wait_i,
   output logic              wr_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   lane_state_e       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LANE_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
      end else if (flush_i) begin
         state_q <= LANE_IDLE;
      end else begin
         unique case (state_q)
            LANE_IDLE: begin
               if (fire_i) begin
                  state_q <= LANE_BUSY;
                  addr_q  <= addr_i;
                  data_q  <= data_i;
               end
            end
            LANE_BUSY: begin
               if (!wait_i) state_q <= LANE_IDLE;
            end
            default: state_q <= LANE_IDLE;
         endcase
      end
   end

   assign wr_o   = (state_q == LANE_BUSY);
   assign addr_o = addr_q;
   assign data_o = data_q;
endmodule

// File: rtl/cfg_write_bridge.sv
module cfg_write_bridge
   import cwb_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned CTRL_W       = 32,
   parameter int unsigned ADDR_W       = 6,
   parameter int unsigned ADDR_LSB     = 8,
   parameter int unsigned NUM_TGT      = 2,
   parameter int unsigned WR_LSB       = 0,
   parameter int unsigned RCFG_RST_BIT = 2,
   parameter int unsigned CLK_RST_BIT  = 3,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [DATA_W-1:0]          host_param_i,
   input  logic [CTRL_W-1:0]          host_ctrl_i,
   output logic [NUM_TGT-1:0]         cfg_wr_o,
   input  logic [NUM_TGT-1:0]         cfg_wait_i,
   output logic [NUM_TGT*ADDR_W-1:0]  cfg_addr_o,
   output logic [NUM_TGT*DATA_W-1:0]  cfg_wdata_o,
   output logic                       cfg_logic_rst_o,
   output logic                       clkgen_rst_o
);
   localparam int unsigned SYNC_W    = NUM_TGT + 2;
   localparam int unsigned IDX_RCFG  = NUM_TGT;
   localparam int unsigned IDX_CLK   = NUM_TGT + 1;
   localparam int unsigned WR_MSB    = WR_LSB + NUM_TGT - 1;
   localparam int unsigned ADDR_MSB  = ADDR_LSB + ADDR_W - 1;

   generate
      if (NUM_TGT < 1 || NUM_TGT > CWB_MAX_TGT) begin : g_bad_tgt
         $error("cfg_write_bridge: NUM_TGT out of range");
      end
      if (ADDR_MSB >= CTRL_W || WR_MSB >= CTRL_W ||
          RCFG_RST_BIT >= CTRL_W || CLK_RST_BIT >= CTRL_W) begin : g_bad_pos
         $error("cfg_write_bridge: control field outside control word");
      end
      if (RCFG_RST_BIT == CLK_RST_BIT) begin : g_bad_rst
         $error("cfg_write_bridge: reset bits must differ");
      end
      if ((RCFG_RST_BIT >= WR_LSB && RCFG_RST_BIT <= WR_MSB) ||
          (CLK_RST_BIT >= WR_LSB && CLK_RST_BIT <= WR_MSB)) begin : g_bad_ovl
         $error("cfg_write_bridge: reset bit overlaps a write bit");
      end
   endgenerate

   logic [SYNC_W-1:0]  raw_bits;
   logic [SYNC_W-1:0]  sync_bits;
   logic [NUM_TGT-1:0] fire;
   logic               flush;
   logic [ADDR_W-1:0]  addr_field;
   logic               unused_ctrl;

   assign raw_bits   = {host_ctrl_i[CLK_RST_BIT], host_ctrl_i[RCFG_RST_BIT],
                        host_ctrl_i[WR_LSB +: NUM_TGT]};
   assign addr_field = host_ctrl_i[ADDR_LSB +: ADDR_W];
   assign unused_ctrl = ^host_ctrl_i;

   cwb_sync #(
      .WIDTH  (SYNC_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_bits),
      .q_o   (sync_bits)
   );

   cwb_edge #(
      .WIDTH (NUM_TGT)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (sync_bits[NUM_TGT-1:0]),
      .rise_o (fire)
   );

   assign cfg_logic_rst_o = sync_bits[IDX_RCFG];
   assign clkgen_rst_o    = sync_bits[IDX_CLK];
   assign flush           = sync_bits[IDX_RCFG] | sync_bits[IDX_CLK];

   generate
      for (genvar t = 0; t < NUM_TGT; t++) begin : g_lane
         cwb_lane #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
         ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush_i (flush),
            .fire_i  (fire[t]),
            .addr_i  (addr_field),
            .data_i  (host_param_i),
            .wait_i  (cfg_wait_i[t]),
            .wr_o    (cfg_wr_o[t]),
            .addr_o  (cfg_addr_o[t*ADDR_W +: ADDR_W]),
            .data_o  (cfg_wdata_o[t*DATA_W +: DATA_W])
         );
      end
   endgenerate
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CTRL_W  = 32,
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned NUM_TGT = 2,
   parameter int unsigned WR_LSB  = 0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [CTRL_W-1:0]         host_ctrl_i,
   input logic [NUM_TGT-1:0]        cfg_wr_o,
   input logic [NUM_TGT-1:0]        cfg_wait_i,
   input logic [NUM_TGT*ADDR_W-1:0] cfg_addr_o,
   input logic [NUM_TGT*DATA_W-1:0] cfg_wdata_o,
   input logic                      cfg_logic_rst_o,
   input logic                      clkgen_rst_o
);
   generate
      for (genvar t = 0; t < NUM_TGT; t++) begin : g_chk
         // R2: a strobe only rises after its request bit was sampled high two edges before
         a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cfg_wr_o[t]) |-> $past(host_ctrl_i[WR_LSB+t], 2));

         // R4: stalled write keeps strobe, address and data
         a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_o[t] && cfg_wait_i[t] && !cfg_logic_rst_o && !clkgen_rst_o)
            |=> (cfg_wr_o[t] && $stable(cfg_addr_o[t*ADDR_W +: ADDR_W])
                 && $stable(cfg_wdata_o[t*DATA_W +: DATA_W])));

         // R4: accepted write ends on the next edge
         a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_o[t] && !cfg_wait_i[t]) |=> !cfg_wr_o[t]);

         // R7: an active reset output empties the lane
         a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_logic_rst_o || clkgen_rst_o) |=> !cfg_wr_o[t]);
      end
   endgenerate
endmodule

bind cfg_write_bridge cwb_checker #(
   .DATA_W  (DATA_W),
   .CTRL_W  (CTRL_W),
   .ADDR_W  (ADDR_W),
   .NUM_TGT (NUM_TGT),
   .WR_LSB  (WR_LSB)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .host_ctrl_i     (host_ctrl_i),
   .cfg_wr_o        (cfg_wr_o),
   .cfg_wait_i      (cfg_wait_i),
   .cfg_addr_o      (cfg_addr_o),
   .cfg_wdata_o     (cfg_wdata_o),
   .cfg_logic_rst_o (cfg_logic_rst_o),
   .clkgen_rst_o    (clkgen_rst_o)
);

// File: tb/cfg_write_bridge_tb.sv
module cfg_write_bridge_tb;
   localparam int AW = 6;
   localparam int DW = 32;
   localparam int NT = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [DW-1:0]  host_param = '0;
   logic [31:0]    host_ctrl = '0;
   logic [NT-1:0]  wr;
   logic [NT-1:0]  wait_r = '0;
   logic [NT*AW-1:0] addr;
   logic [NT*DW-1:0] wdata;
   logic           lrst, crst;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   cfg_write_bridge u_dut (
      .clk (clk), .rst_n (rst_n),
      .host_param_i (host_param), .host_ctrl_i (host_ctrl),
      .cfg_wr_o (wr), .cfg_wait_i (wait_r),
      .cfg_addr_o (addr), .cfg_wdata_o (wdata),
      .cfg_logic_rst_o (lrst), .clkgen_rst_o (crst)
   );

   // ---------------- reference model ----------------
   logic [31:0] hist[$];
   logic [NT-1:0] m_wr;
   logic [AW-1:0] m_addr [NT];
   logic [DW-1:0] m_data [NT];
   logic m_lrst, m_crst;
   int done_cnt [NT];
   logic [AW-1:0] last_addr [NT];
   logic [DW-1:0] last_data [NT];

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{32'h0, 32'h0, 32'h0};
         m_wr = '0;
         m_lrst = 0; m_crst = 0;
         for (int i = 0; i < NT; i++) begin
            m_addr[i] = '0; m_data[i] = '0;
            done_cnt[i] = 0; last_addr[i] = '0; last_data[i] = '0;
         end
      end else begin
         for (int i = 0; i < NT; i++) begin
            if (wr[i] && !wait_r[i]) begin
               done_cnt[i]++;
               last_addr[i] = addr[i*AW +: AW];
               last_data[i] = wdata[i*DW +: DW];
            end
            if (hist[1][2] || hist[1][3]) m_wr[i] = 1'b0;
            else if (m_wr[i]) begin
               if (!wait_r[i]) m_wr[i] = 1'b0;
            end else if (hist[1][i] && !hist[2][i]) begin
               m_wr[i] = 1'b1;
               m_addr[i] = host_ctrl[13:8];
               m_data[i] = host_param;
            end
         end
         m_lrst = hist[0][2];
         m_crst = hist[0][3];
         hist.push_front(host_ctrl);
         void'(hist.pop_back());
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic ok;
         ok = (wr === m_wr) && (lrst === m_lrst) && (crst === m_crst);
         for (int i = 0; i < NT; i++)
            if (m_wr[i])
               ok = ok && (addr[i*AW +: AW] === m_addr[i]) &&
                         (wdata[i*DW +: DW] === m_data[i]);
         checks++;
         if (!ok) begin
            errors++;
            $display("FAIL %s model: act wr=%b lrst=%b crst=%b addr=%h data=%h exp wr=%b lrst=%b crst=%b addr0=%h data0=%h",
                     cur_req, wr, lrst, crst, addr, wdata, m_wr, m_lrst, m_crst,
                     m_addr[0], m_data[0]);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit cond, input string req, input longint act, input longint exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [5:0] a, input bit w0, input bit w1,
                                      input bit rr, input bit cr);
      logic [31:0] c;
      c = '0;
      c[13:8] = a;
      c[0] = w0; c[1] = w1; c[2] = rr; c[3] = cr;
      return c;
   endfunction

   initial begin
      #(8 * 100000);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog: act=timeout exp=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(5);
      // R1: reset state
      chk(wr == 0 && addr == 0 && wdata == 0 && !lrst && !crst, "R1", {wr, lrst, crst}, 0);
      rst_n = 1'b1;
      cyc(2);
      chk(wr == 0 && !lrst && !crst, "R1", {wr, lrst, crst}, 0);

      // R2: single write, latency and contents
      cur_req = "R2";
      host_param = 32'hCAFE_0001;
      host_ctrl = mk(6'h05, 0, 0, 0, 0);
      cyc(2);
      host_ctrl = mk(6'h05, 1, 0, 0, 0);
      cyc(2);
      chk(wr[0] == 0, "R2", wr[0], 0);
      cyc(1);
      chk(wr[0] == 1, "R2", wr[0], 1);
      cyc(1);
      chk(wr[0] == 0, "R2", wr[0], 0);
      cyc(3);
      chk(done_cnt[0] == 1, "R2", done_cnt[0], 1);
      chk(last_addr[0] == 6'h05, "R2", last_addr[0], 5);
      chk(last_data[0] == 32'hCAFE_0001, "R2", last_data[0], 32'hCAFE_0001);

      // R3: held bit gives one write; re-arm gives another
      cur_req = "R3";
      cyc(20);
      chk(done_cnt[0] == 1, "R3", done_cnt[0], 1);
      host_ctrl = mk(6'h1C, 0, 0, 0, 0);
      cyc(4);
      host_param = 32'h1234_5678;
      host_ctrl = mk(6'h1C, 1, 0, 0, 0);
      cyc(6);
      chk(done_cnt[0] == 2, "R3", done_cnt[0], 2);
      chk(last_addr[0] == 6'h1C, "R3", last_addr[0], 6'h1C);
      chk(last_data[0] == 32'h1234_5678, "R3", last_data[0], 32'h1234_5678);

      // R4: stall holds contents while host registers change
      cur_req = "R4";
      wait_r[0] = 1'b1;
      host_ctrl = mk(6'h06, 0, 0, 0, 0);
      host_param = 32'hA5A5_0F0F;
      cyc(4);
      host_ctrl = mk(6'h06, 1, 0, 0, 0);
      cyc(4);
      host_param = 32'hFFFF_FFFF;
      host_ctrl = mk(6'h02, 1, 0, 0, 0);
      cyc(5);
      chk(wr[0] == 1, "R4", wr[0], 1);
      chk(addr[AW-1:0] == 6'h06, "R4", addr[AW-1:0], 6);
      chk(wdata[DW-1:0] == 32'hA5A5_0F0F, "R4", wdata[DW-1:0], 32'hA5A5_0F0F);
      wait_r[0] = 1'b0;
      cyc(1);
      chk(wr[0] == 0, "R4", wr[0], 0);
      chk(done_cnt[0] == 3 && last_addr[0] == 6'h06, "R4", done_cnt[0], 3);

      // R5: second lane
      cur_req = "R5";
      host_ctrl = mk(6'h03, 0, 0, 0, 0);
      cyc(4);
      host_param = 32'h0000_0101;
      host_ctrl = mk(6'h03, 0, 1, 0, 0);
      cyc(6);
      chk(done_cnt[1] == 1, "R5", done_cnt[1], 1);
      chk(last_addr[1] == 6'h03 && last_data[1] == 32'h0000_0101, "R5", last_data[1], 32'h101);
      chk(done_cnt[0] == 3, "R5", done_cnt[0], 3);

      // R6: reset outputs
      cur_req = "R6";
      host_ctrl = mk(6'h00, 0, 0, 0, 1);
      cyc(1);
      chk(crst == 0, "R6", crst, 0);
      cyc(1);
      chk(crst == 1 && lrst == 0, "R6", {crst, lrst}, 2'b10);
      host_ctrl = mk(6'h00, 0, 0, 1, 1);
      cyc(3);
      chk(crst == 1 && lrst == 1, "R6", {crst, lrst}, 2'b11);
      host_ctrl = mk(6'h00, 0, 0, 0, 0);
      cyc(3);
      chk(crst == 0 && lrst == 0, "R6", {crst, lrst}, 2'b00);

      // R7: reset cancels pending write; edge under reset is lost
      cur_req = "R7";
      wait_r[0] = 1'b1;
      host_ctrl = mk(6'h04, 1, 0, 0, 0);
      cyc(5);
      chk(wr[0] == 1, "R7", wr[0], 1);
      host_ctrl = mk(6'h04, 1, 0, 1, 0);
      cyc(3);
      chk(wr[0] == 0, "R7", wr[0], 0);
      wait_r[0] = 1'b0;
      cyc(3);
      host_ctrl = mk(6'h04, 0, 0, 1, 0);
      cyc(3);
      host_ctrl = mk(6'h04, 1, 0, 1, 0);
      cyc(3);
      host_ctrl = mk(6'h04, 1, 0, 0, 0);
      cyc(6);
      chk(wr[0] == 0, "R7", wr[0], 0);
      chk(done_cnt[0] == 3, "R7", done_cnt[0], 3);

      // R8: edge during a pending write is dropped
      cur_req = "R8";
      wait_r[0] = 1'b1;
      host_ctrl = mk(6'h07, 0, 0, 0, 0);
      cyc(4);
      host_ctrl = mk(6'h07, 1, 0, 0, 0);
      cyc(5);
      host_ctrl = mk(6'h07, 0, 0, 0, 0);
      cyc(4);
      host_ctrl = mk(6'h07, 1, 0, 0, 0);
      cyc(4);
      wait_r[0] = 1'b0;
      cyc(4);
      chk(done_cnt[0] == 4, "R8", done_cnt[0], 4);
      chk(wr[0] == 0 && last_addr[0] == 6'h07, "R8", last_addr[0], 7);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule